// File: doc/BRIEF.md
# GPIO Bank with Grouped Interrupts

This block is a bank of 32 general-purpose I/O lines controlled through a small 32-bit register bus. The bus has a word address, a write strobe, write data and combinational read data. Software sets each line's output value and direction, and can invert how the input is read. It also enables edge and level interrupt sources per line. A line can instead be handed to one of two external blink waveforms, so that it flashes without software involvement.

Every input first passes through a two-flop synchroniser. The synchronised value is then XORed with the line's polarity bit. The result is the value software reads as data in, and it is also what the interrupt logic sees. Because of this, one rising-edge detector covers both rising and falling pins. A rising transition of a line is latched into an edge-cause register, and software clears that register by writing zeros. The masked edge causes and the masked level causes are ORed in groups of eight lines to form four interrupt request outputs.

Top module: `pinbank_irq`

## Requirements
- R1: After reset, all writable registers, the edge-cause register and the data-in value read as zero. The interrupt outputs are low, every line is an output (pin_oe all ones) and pin_out is zero.
- R2: A direction bit of 1 makes its line an input (pin_oe bit 0). A direction bit of 0 makes it an output (pin_oe bit 1) that drives the output-data bit when blinking is off.
- R3: When a line's blink-enable bit is 1, pin_out for that line is its output-data bit ANDed with blink_wave_a if its blink-select bit is 0, or with blink_wave_b if that bit is 1.
- R4: Reading the data-in word returns the pin value XORed with the polarity register, taken from the pin two clock edges earlier.
- R5: A 0-to-1 change of a line's data-in value sets its edge-cause bit on the following clock edge. A 1-to-0 change does not set it. Setting the polarity bit therefore lets a falling pin be caught.
- R6: A write to the edge-cause word clears each bit written as 0 and leaves unchanged each bit written as 1.
- R7: If a new edge arrives on the same clock edge as a write that clears its cause bit, the bit remains set.
- R8: A line whose level-mask bit is 1 asserts its group's interrupt while its data-in bit is 1, without any latching.
- R9: irq_grp[k] is the OR, over lines 8k to 8k+7, of (edge cause AND edge mask) OR (data in AND level mask).
- R10: Word addresses are: 0 output data, 1 direction, 2 polarity, 3 blink enable, 4 blink select, 5 data in (read-only), 6 edge cause, 7 edge mask, 8 level mask. Writes to address 5 are ignored, and reads of unused addresses return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 4 | Register word address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| pin_in | input | 32 | Raw pin levels, asynchronous |
| pin_out | output | 32 | Pin drive value |
| pin_oe | output | 32 | Pin output enable, 1 = driving |
| blink_wave_a | input | 1 | First external blink waveform |
| blink_wave_b | input | 1 | Second external blink waveform |
| irq_grp | output | 4 | Interrupt request per group of eight lines |

## Verification
A software clear of the edge-cause word and a newly detected edge can land on the same clock edge, and the two disagree on the bit's next value. The bench provokes this by raising a pin and timing a clearing write for exactly the edge on which the synchronised, polarity-adjusted value first reads high. That write also clears another cause bit that was already set. The expected result is that the fresh bit survives and the older bit is gone, which separates "new edge wins" from both "clear wins" and "write ignored".

// File: rtl/pinbank_pkg.sv
package pinbank_pkg;
  localparam int unsigned LINES   = 32;
  localparam int unsigned GROUP   = 8;
  localparam int unsigned AW      = 4;

  // Register word addresses
  localparam logic [AW-1:0] RA_OUT   = 4'd0;
  localparam logic [AW-1:0] RA_DIR   = 4'd1;
  localparam logic [AW-1:0] RA_POL   = 4'd2;
  localparam logic [AW-1:0] RA_BLINK = 4'd3;
  localparam logic [AW-1:0] RA_BSEL  = 4'd4;
  localparam logic [AW-1:0] RA_DIN   = 4'd5;
  localparam logic [AW-1:0] RA_CAUSE = 4'd6;
  localparam logic [AW-1:0] RA_EMASK = 4'd7;
  localparam logic [AW-1:0] RA_LMASK = 4'd8;
endpackage

// File: rtl/pinbank_sync.sv
module pinbank_sync #(
  parameter int unsigned W = pinbank_pkg::LINES
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_in,
  input  logic [W-1:0] pol,
  output logic [W-1:0] din
);
  logic [W-1:0] meta_q, stab_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      stab_q <= '0;
    end else begin
      meta_q <= pin_in;
      stab_q <= meta_q;
    end
  end

  assign din = stab_q ^ pol;
endmodule

// File: rtl/pinbank_regs.sv
module pinbank_regs
  import pinbank_pkg::*;
#(
  parameter int unsigned W = LINES
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wdata,
  input  logic [W-1:0]  din,
  input  logic [W-1:0]  cause,
  output logic [W-1:0]  rdata,
  output logic          cause_we,
  output logic [W-1:0]  out_q,
  output logic [W-1:0]  dir_q,
  output logic [W-1:0]  pol_q,
  output logic [W-1:0]  blink_q,
  output logic [W-1:0]  bsel_q,
  output logic [W-1:0]  emask_q,
  output logic [W-1:0]  lmask_q
);
  logic en_out, en_dir, en_pol, en_blink, en_bsel, en_emask, en_lmask;

  always_comb begin
    en_out   = we && (addr == RA_OUT);
    en_dir   = we && (addr == RA_DIR);
    en_pol   = we && (addr == RA_POL);
    en_blink = we && (addr == RA_BLINK);
    en_bsel  = we && (addr == RA_BSEL);
    en_emask = we && (addr == RA_EMASK);
    en_lmask = we && (addr == RA_LMASK);
    cause_we = we && (addr == RA_CAUSE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q   <= '0;
      dir_q   <= '0;
      pol_q   <= '0;
      blink_q <= '0;
      bsel_q  <= '0;
      emask_q <= '0;
      lmask_q <= '0;
    end else begin
      if (en_out)   out_q   <= wdata;
      if (en_dir)   dir_q   <= wdata;
      if (en_pol)   pol_q   <= wdata;
      if (en_blink) blink_q <= wdata;
      if (en_bsel)  bsel_q  <= wdata;
      if (en_emask) emask_q <= wdata;
      if (en_lmask) lmask_q <= wdata;
    end
  end

  always_comb begin
    unique case (addr)
      RA_OUT:   rdata = out_q;
      RA_DIR:   rdata = dir_q;
      RA_POL:   rdata = pol_q;
      RA_BLINK: rdata = blink_q;
      RA_BSEL:  rdata = bsel_q;
      RA_DIN:   rdata = din;
      RA_CAUSE: rdata = cause;
      RA_EMASK: rdata = emask_q;
      RA_LMASK: rdata = lmask_q;
      default:  rdata = '0;
    endcase
  end

  // R10
  out_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == RA_OUT) |=> (out_q == $past(wdata)));
endmodule

// File: rtl/pinbank_irq_logic.sv
module pinbank_irq_logic #(
  parameter int unsigned W = pinbank_pkg::LINES,
  parameter int unsigned G = pinbank_pkg::GROUP
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [W-1:0]   din,
  input  logic           cause_we,
  input  logic [W-1:0]   wdata,
  input  logic [W-1:0]   emask,
  input  logic [W-1:0]   lmask,
  output logic [W-1:0]   cause_q,
  output logic [W/G-1:0] irq
);
  localparam int unsigned NG = W / G;

  logic [W-1:0] din_q, rise, cause_d, pend;

  always_comb begin
    rise    = din & ~din_q;
    cause_d = (cause_we ? (cause_q & wdata) : cause_q) | rise;
    pend    = (cause_q & emask) | (din & lmask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      din_q   <= '0;
      cause_q <= '0;
    end else begin
      din_q   <= din;
      cause_q <= cause_d;
    end
  end

  for (genvar g = 0; g < NG; g++) begin : g_grp
    assign irq[g] = |pend[g*G +: G];
  end

  // R5
  edge_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((din & ~din_q) != '0) |=> ((cause_q & $past(din & ~din_q)) == $past(din & ~din_q)));
  // R6
  clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cause_we |=> ((cause_q & ~$past(wdata)) == ($past(din & ~din_q) & ~$past(wdata))));
  // R6
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cause_we && ((din & ~din_q) == '0)) |=> $stable(cause_q));
  // R9
  quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (emask == '0 && lmask == '0) |-> (irq == '0));
endmodule

// File: rtl/pinbank_irq.sv
module pinbank_irq
  import pinbank_pkg::*;
#(
  parameter int unsigned W = LINES,
  parameter int unsigned G = GROUP
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [AW-1:0]  bus_addr,
  input  logic           bus_we,
  input  logic [W-1:0]   bus_wdata,
  output logic [W-1:0]   bus_rdata,
  input  logic [W-1:0]   pin_in,
  output logic [W-1:0]   pin_out,
  output logic [W-1:0]   pin_oe,
  input  logic           blink_wave_a,
  input  logic           blink_wave_b,
  output logic [W/G-1:0] irq_grp
);
  logic [W-1:0] din, cause, out_q, dir_q, pol_q, blink_q, bsel_q, emask_q, lmask_q;
  logic         cause_we;

  pinbank_sync #(.W(W)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .pol(pol_q), .din(din)
  );

  pinbank_regs #(.W(W)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
    .din(din), .cause(cause), .rdata(bus_rdata), .cause_we(cause_we),
    .out_q(out_q), .dir_q(dir_q), .pol_q(pol_q), .blink_q(blink_q),
    .bsel_q(bsel_q), .emask_q(emask_q), .lmask_q(lmask_q)
  );

  pinbank_irq_logic #(.W(W), .G(G)) u_irq (
    .clk(clk), .rst_n(rst_n), .din(din), .cause_we(cause_we), .wdata(bus_wdata),
    .emask(emask_q), .lmask(lmask_q), .cause_q(cause), .irq(irq_grp)
  );

  for (genvar i = 0; i < W; i++) begin : g_pad
    logic wave;
    assign wave       = bsel_q[i] ? blink_wave_b : blink_wave_a;
    assign pin_out[i] = out_q[i] & (~blink_q[i] | wave);
    assign pin_oe[i]  = ~dir_q[i];
  end
endmodule

// File: tb/pinbank_irq_test.sv
module pinbank_irq_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  bus_addr;
  logic        bus_we;
  logic [31:0] bus_wdata, bus_rdata, pin_in, pin_out, pin_oe;
  logic        blink_wave_a, blink_wave_b;
  logic [3:0]  irq_grp;

  int nvec = 0;
  int nfail = 0;

  always #10 clk = ~clk;

  pinbank_irq uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .blink_wave_a(blink_wave_a),
    .blink_wave_b(blink_wave_b), .irq_grp(irq_grp)
  );

  // {pins, polarity, expected data-in}
  localparam logic [95:0] VEC [6] = '{
    {32'h0000_0000, 32'h0000_0000, 32'h0000_0000},
    {32'hFFFF_FFFF, 32'h0000_0000, 32'hFFFF_FFFF},
    {32'h1234_5678, 32'h0000_0000, 32'h1234_5678},
    {32'h1234_5678, 32'hFFFF_FFFF, 32'hEDCB_A987},
    {32'h0000_0000, 32'hF0F0_F0F0, 32'hF0F0_F0F0},
    {32'hAAAA_5555, 32'h0F0F_0F0F, 32'hA5A5_5A5A}
  };

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    cyc(1);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  initial begin
    #(200000 * 20);
    nfail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    rst_n = 1'b0; bus_addr = '0; bus_we = 1'b0; bus_wdata = '0;
    pin_in = '0; blink_wave_a = 1'b0; blink_wave_b = 1'b0;
    cyc(3);
    rst_n = 1'b1;
    cyc(1);

    // R1 reset state
    for (int a = 0; a < 9; a++) begin
      rd(4'(a), v);
      chk($sformatf("R1 reg %0d", a), v, 32'h0);
    end
    chk("R1 irq", {28'h0, irq_grp}, 32'h0);
    chk("R1 oe", pin_oe, 32'hFFFF_FFFF);
    chk("R1 out", pin_out, 32'h0);

    // R4 table of pin/polarity vectors
    for (int k = 0; k < 6; k++) begin
      pin_in = VEC[k][95:64];
      wr(4'd2, VEC[k][63:32]);
      cyc(2);
      rd(4'd5, v);
      chk($sformatf("R4 vector %0d", k), v, VEC[k][31:0]);
    end
    pin_in = '0;
    wr(4'd2, 32'h0);
    cyc(3);
    wr(4'd6, 32'h0);

    // R2 direction and output
    wr(4'd0, 32'hA5A5_A5A5);
    wr(4'd1, 32'h0000_FFFF);
    chk("R2 oe", pin_oe, 32'hFFFF_0000);
    chk("R2 out", pin_out, 32'hA5A5_A5A5);
    rd(4'd1, v);
    chk("R10 dir readback", v, 32'h0000_FFFF);

    // R3 blink
    wr(4'd0, 32'hFFFF_FFFF);
    wr(4'd3, 32'h0000_000F);
    wr(4'd4, 32'h0000_000C);
    blink_wave_a = 1'b1; blink_wave_b = 1'b0; #1;
    chk("R3 wave a", pin_out, 32'hFFFF_FFF3);
    blink_wave_a = 1'b0; blink_wave_b = 1'b1; #1;
    chk("R3 wave b", pin_out, 32'hFFFF_FFFC);

    // R10 read-only and unused address
    wr(4'd5, 32'hDEAD_BEEF);
    rd(4'd5, v);
    chk("R10 din write ignored", v, 32'h0);
    rd(4'd12, v);
    chk("R10 unused reads zero", v, 32'h0);

    // R5 rising edge latch, R9 group 1
    wr(4'd7, 32'h0000_0200);
    pin_in[9] = 1'b1;
    cyc(2);
    rd(4'd6, v);
    chk("R5 cause not yet", v, 32'h0);
    cyc(1);
    rd(4'd6, v);
    chk("R5 cause set", v, 32'h0000_0200);
    chk("R9 group1 irq", {28'h0, irq_grp}, 32'h2);
    pin_in[9] = 1'b0;
    cyc(3);
    rd(4'd6, v);
    chk("R5 falling no new cause", v, 32'h0000_0200);

    // R6 write-one keeps, write-zero clears
    wr(4'd6, 32'hFFFF_FFFF);
    rd(4'd6, v);
    chk("R6 ones keep", v, 32'h0000_0200);
    wr(4'd6, 32'hFFFF_FDFF);
    rd(4'd6, v);
    chk("R6 zero clears", v, 32'h0);
    chk("R6 irq dropped", {28'h0, irq_grp}, 32'h0);

    // R5 falling pin caught through polarity
    pin_in[20] = 1'b1;
    cyc(4);
    wr(4'd6, 32'h0);
    wr(4'd2, 32'h0010_0000);
    cyc(2);
    rd(4'd6, v);
    chk("R5 polarity flip no edge", v, 32'h0);
    pin_in[20] = 1'b0;
    cyc(3);
    rd(4'd6, v);
    chk("R5 inverted falling edge", v, 32'h0010_0000);

    // R7 clear collides with new edge
    pin_in[3] = 1'b1;
    cyc(2);
    wr(4'd6, 32'h0);
    rd(4'd6, v);
    chk("R7 new edge wins over clear", v, 32'h0000_0008);

    // R8 level interrupt, group 3
    wr(4'd8, 32'h0400_0000);
    pin_in[26] = 1'b1;
    cyc(1);
    chk("R8 level not yet", {28'h0, irq_grp}, 32'h0);
    cyc(1);
    chk("R8 level irq", {28'h0, irq_grp}, 32'h8);

    // R9 grouping with edge mask fully open
    wr(4'd7, 32'hFFFF_FFFF);
    wr(4'd8, 32'h0);
    rd(4'd6, v);
    chk("R9 cause content", v, 32'h0400_0008);
    chk("R9 groups 0 and 3", {28'h0, irq_grp}, 32'h9);
    wr(4'd6, 32'hFFFF_FFF7);
    chk("R9 group 0 cleared", {28'h0, irq_grp}, 32'h8);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule